// File: doc/BRIEF.md
# Multi-Mode Buzzer Tone Generator

This block produces a square-wave buzzer signal. Its clock is the 75 kHz timebase. A 2-bit pitch select picks one of four tones: 0.75 kHz, 1 kHz, 1.5 kHz or 3 kHz. A 2-bit pattern select picks how the tone is gated:

- steady,
- a single 100 ms shot,
- 10 Hz bursts,
- 10 Hz bursts sounding only in the first half of every second.

Sound begins on a start strobe while the enable is high. It continues until the enable drops. In single-shot mode it also stops when the shot time runs out. A busy flag shows that a sound is in progress. All pins are plain control and status levels. The block has no streaming interface and no back-pressure.

Timing is counted in timebase cycles. A start strobe seen at a clock edge makes busy high from the next cycle. In that same cycle the tone output begins its high half-period. Output changes always follow the clock edge that caused them.

Top module: `bz_tone_gen`

## Requirements
- R1: After reset, `buzz` and `busy` are low until a start strobe is accepted.
- R2: Pitch select 0, 1, 2 and 3 give tone periods of 100, 75, 50 and 25 clocks. Each period starts high for ceil(P/2) clocks and then is low for floor(P/2) clocks.
- R3: When `start` is high with `en` high at an edge, `busy` is high from the next cycle. The tone and the pattern timing both restart from their beginning at that cycle. This also applies during a sound already in progress.
- R4: Pattern 0 (steady) drives the ungated tone for as long as `en` stays high.
- R5: Pattern 1 (single-shot) keeps `busy` high for exactly 7500 clocks (100 ms) after the accepting edge, then returns to idle with `buzz` low. A new strobe during the shot restarts the 7500-clock window.
- R6: Pattern 2 (10 Hz) repeats a 7500-clock cycle: the tone sounds for the first 3750 clocks and is silent for the next 3750.
- R7: Pattern 3 repeats a 75000-clock cycle. The R6 burst pattern runs for the first 37500 clocks, and the output is silent for the remaining 37500.
- R8: With `en` low, `busy` and `buzz` are low from the next cycle, and `start` has no effect.
- R9: A change of the pitch select restarts the tone period at its high half on the cycle after the change.
- R10: A change of the pattern select while sounding restarts the pattern timing from zero on the cycle after the change. `busy` is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 75 kHz timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low forces silence and idle |
| start | input | 1 | Start/retrigger strobe, sampled at each edge |
| freq_sel | input | 2 | Pitch select: 0=0.75 kHz, 1=1 kHz, 2=1.5 kHz, 3=3 kHz |
| mode_sel | input | 2 | Pattern select: 0 steady, 1 single-shot, 2 10 Hz bursts, 3 bursts in first half-second |
| buzz | output | 1 | Buzzer square wave |
| busy | output | 1 | High while a sound is in progress |

## Verification
The odd periods of 75 and 25 clocks are the first target. A divider that splits them wrongly, or that starts a period in its low half, moves `buzz` edges by one clock against the model. A pitch change in mid-tone and a retrigger in mid-shot are applied to catch a divider or shot timer that keeps its old phase. The shot end is checked at exactly 7500 clocks, so an off-by-one timer gives one busy cycle too many or too few. A full second of the grouped pattern is run to expose a burst gate that forgets the silent half-second. The bench also probes a strobe while disabled, and a design that honoured it would raise `busy`.

// File: rtl/bz_pkg.sv
package bz_pkg;
  typedef enum logic [1:0] {
    BZ_STEADY = 2'd0,
    BZ_SHOT   = 2'd1,
    BZ_BURST  = 2'd2,
    BZ_GROUP  = 2'd3
  } bz_mode_e;
endpackage

// File: rtl/bz_tone_div.sv
module bz_tone_div #(
  parameter int CLK_HZ = 75000,
  parameter int F0 = 750,
  parameter int F1 = 1000,
  parameter int F2 = 1500,
  parameter int F3 = 3000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] fsel,
  output logic       tone
);
  localparam int FMIN01 = (F0 < F1) ? F0 : F1;
  localparam int FMIN23 = (F2 < F3) ? F2 : F3;
  localparam int FMIN   = (FMIN01 < FMIN23) ? FMIN01 : FMIN23;
  localparam int PW     = $clog2(CLK_HZ / FMIN + 1);
  localparam logic [PW-1:0] PER0 = PW'(CLK_HZ / F0);
  localparam logic [PW-1:0] PER1 = PW'(CLK_HZ / F1);
  localparam logic [PW-1:0] PER2 = PW'(CLK_HZ / F2);
  localparam logic [PW-1:0] PER3 = PW'(CLK_HZ / F3);

  logic [1:0]    fsel_q;
  logic [PW-1:0] cnt, period, hi_len;

  always_comb begin
    case (fsel_q)
      2'd0:    period = PER0;
      2'd1:    period = PER1;
      2'd2:    period = PER2;
      default: period = PER3;
    endcase
    hi_len = period - (period >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q <= '0;
      cnt    <= '0;
    end else begin
      fsel_q <= fsel;
      if (restart || !run || (fsel != fsel_q)) cnt <= '0;
      else if (cnt == period - 1'b1)          cnt <= '0;
      else                                     cnt <= cnt + 1'b1;
    end
  end

  assign tone = (cnt < hi_len);

  a_r2_phase_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < period) else $error("tone phase beyond period");

  a_r9_pitch_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel != fsel_q) |=> (cnt == '0)) else $error("pitch change did not restart tone");
endmodule

// File: rtl/bz_envelope.sv
module bz_envelope
  import bz_pkg::*;
#(
  parameter int CLK_HZ = 75000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       start,
  input  logic [1:0] mode,
  output logic       active,
  output logic       gate
);
  localparam int BURST = CLK_HZ / 20;
  localparam int SEC   = CLK_HZ;
  localparam int SHOT  = CLK_HZ / 10;
  localparam int SW    = $clog2(SEC);
  localparam int BW    = $clog2(2 * BURST);
  localparam logic [SW-1:0] SEC_LAST  = SW'(SEC - 1);
  localparam logic [SW-1:0] SEC_HALF  = SW'(SEC / 2);
  localparam logic [SW-1:0] SHOT_LAST = SW'(SHOT - 1);
  localparam logic [BW-1:0] BUR_LAST  = BW'(2 * BURST - 1);
  localparam logic [BW-1:0] BUR_ON    = BW'(BURST);

  bz_mode_e      mode_q;
  logic [SW-1:0] sec_cnt;
  logic [BW-1:0] bur_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= BZ_STEADY;
      active  <= 1'b0;
      sec_cnt <= '0;
      bur_cnt <= '0;
    end else begin
      mode_q <= bz_mode_e'(mode);
      if (!en) begin
        active  <= 1'b0;
        sec_cnt <= '0;
        bur_cnt <= '0;
      end else if (start) begin
        active  <= 1'b1;
        sec_cnt <= '0;
        bur_cnt <= '0;
      end else if (mode != mode_q) begin
        sec_cnt <= '0;
        bur_cnt <= '0;
      end else if (active) begin
        if (mode_q == BZ_SHOT && sec_cnt == SHOT_LAST) begin
          active  <= 1'b0;
          sec_cnt <= '0;
          bur_cnt <= '0;
        end else begin
          sec_cnt <= (sec_cnt == SEC_LAST) ? '0 : sec_cnt + 1'b1;
          bur_cnt <= (bur_cnt == BUR_LAST) ? '0 : bur_cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (mode_q)
      BZ_BURST: gate = (bur_cnt < BUR_ON);
      BZ_GROUP: gate = (bur_cnt < BUR_ON) && (sec_cnt < SEC_HALF);
      default:  gate = 1'b1;
    endcase
  end

  a_r5_stop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(!en) || $past(mode_q) == BZ_SHOT))
    else $error("sound stopped without cause");

  a_r10_pattern_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start && (mode != mode_q)) |=> (sec_cnt == '0 && bur_cnt == '0))
    else $error("pattern change did not restart timing");

  a_r4_steady_open: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == BZ_STEADY) |-> gate) else $error("steady mode gated");
endmodule

// File: rtl/bz_tone_gen.sv
module bz_tone_gen #(
  parameter int CLK_HZ = 75000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       start,
  input  logic [1:0] freq_sel,
  input  logic [1:0] mode_sel,
  output logic       buzz,
  output logic       busy
);
  logic active, gate, tone;

  bz_envelope #(.CLK_HZ(CLK_HZ)) u_env (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .mode(mode_sel),
    .active(active), .gate(gate)
  );

  bz_tone_div #(.CLK_HZ(CLK_HZ)) u_div (
    .clk(clk), .rst_n(rst_n), .run(active), .restart(start && en),
    .fsel(freq_sel), .tone(tone)
  );

  assign busy = active;
  assign buzz = active && gate && tone;

  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !buzz)) else $error("output active while disabled");

  a_r3_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start) |=> (busy && buzz)) else $error("start not accepted");
endmodule

// File: tb/bz_tone_gen_tb.sv
module bz_tone_gen_tb;
  localparam time TCLK = 1000;
  localparam int  WATCHDOG = 195000;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, start = 1'b0;
  logic [1:0] freq_sel = 2'd0, mode_sel = 2'd0;
  logic buzz, busy;
  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(TCLK/2) clk = ~clk;

  bz_tone_gen u_dut (.clk(clk), .rst_n(rst_n), .en(en), .start(start),
                     .freq_sel(freq_sel), .mode_sel(mode_sel), .buzz(buzz), .busy(busy));

  // behavioural reference: elapsed-time based, not counter based
  int  m_ph = 0, m_t = 0, m_fq = 0, m_md = 0;
  bit  m_act = 0;

  function automatic int per_of(input int f);
    int hz[4] = '{750, 1000, 1500, 3000};
    return 75000 / hz[f];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_fq = 0; m_md = 0; m_act = 0;
    end else begin
      if ((start && en) || !m_act || int'(freq_sel) != m_fq) m_ph = 0;
      else m_ph = (m_ph + 1) % per_of(m_fq);
      m_fq = int'(freq_sel);
      if (!en) begin m_act = 0; m_t = 0; end
      else if (start) begin m_act = 1; m_t = 0; end
      else if (int'(mode_sel) != m_md) m_t = 0;
      else if (m_act) begin
        if (m_md == 1 && m_t == 7499) begin m_act = 0; m_t = 0; end
        else m_t = m_t + 1;
      end
      m_md = int'(mode_sel);
    end
  end

  function automatic bit exp_buzz();
    bit g;
    case (m_md)
      2: g = (m_t % 7500) < 3750;
      3: g = ((m_t % 75000) < 37500) && ((m_t % 7500) < 3750);
      default: g = 1;
    endcase
    return m_act && g && (m_ph < per_of(m_fq) - per_of(m_fq) / 2);
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "buzz", buzz, exp_buzz());
      chk(cur_req, "busy", busy, m_act);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1", "busy after reset", busy, 1'b0);
    chk("R1", "buzz after reset", buzz, 1'b0);
    // R4 steady tone, then R2/R9 pitch changes mid-tone
    en = 1'b1; mode_sel = 2'd0; freq_sel = 2'd0;
    cur_req = "R3"; pulse_start();
    cur_req = "R4"; wait_cyc(300);
    cur_req = "R9"; freq_sel = 2'd1; wait_cyc(230);
    cur_req = "R2"; freq_sel = 2'd2; wait_cyc(160);
    freq_sel = 2'd3; wait_cyc(90);
    // R10 pattern change into 10 Hz bursts, R6
    cur_req = "R10"; mode_sel = 2'd2; wait_cyc(20);
    cur_req = "R6"; wait_cyc(16000);
    // R8 disable and ignored strobe
    cur_req = "R8"; en = 1'b0; wait_cyc(20);
    chk("R8", "busy while disabled", busy, 1'b0);
    pulse_start(); wait_cyc(20);
    chk("R8", "busy after strobe while disabled", busy, 1'b0);
    chk("R8", "buzz after strobe while disabled", buzz, 1'b0);
    // R5 single shot with retrigger
    cur_req = "R5"; mode_sel = 2'd1; freq_sel = 2'd3; en = 1'b1; wait_cyc(5);
    pulse_start(); wait_cyc(3000);
    pulse_start(); wait_cyc(7400);
    chk("R5", "busy near shot end", busy, 1'b1);
    wait_cyc(200);
    chk("R5", "busy after shot", busy, 1'b0);
    // R7 bursts during first half-second
    cur_req = "R7"; mode_sel = 2'd3; freq_sel = 2'd1; wait_cyc(3);
    pulse_start(); wait_cyc(80000);
    en = 1'b0; wait_cyc(5);
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule